// File: doc/BRIEF.md
# Poll-Restarted Watchdog with Indicator Latch

This block supervises a host processor that is expected to poll the board. Any read access to the board restarts a timeout counter. No special command or key write is needed. If the host stops reading for a full timeout period, the watchdog drops its OK status. It switches a two-colour indicator from green to red. If the automatic-reset enable is set, it raises a single reboot-request pulse. The default period is 1.6 s at 125 MHz, and the count in clock cycles is a parameter.

A small 16-bit latch register sits alongside the timer:
- its four low bits drive four status LEDs, which the host can use to show boot progress;
- bit 7 holds the automatic-reset enable.

A configuration select chooses what the fourth digital output shows: the watchdog OK status, for an external monitor to sample, or the software-driven output bit 3.

Top module: `poll_watchdog`

## Requirements
- R1: After reset, the watchdog status is OK (1), the four LED bits are 0, the automatic-reset enable is 0, and no reboot request is raised.
- R2: A read strobe sampled high at a clock edge restarts the timeout count. While reads arrive less than TIMEOUT_CYC edges apart, the status stays OK.
- R3: The status falls to 0 on exactly the TIMEOUT_CYC-th clock edge after the last read edge (or after reset release) that had no read.
- R4: Once failed, the status stays 0 until a read. The read edge restores it to 1 and starts a full new timeout period.
- R5: The green lamp equals the watchdog status and the red lamp is its inverse, so exactly one is lit.
- R6: A write strobe loads data bits [3:0] into the four LED outputs and data bit 7 into the automatic-reset enable. A write does not restart the timeout count.
- R7: At a timeout with the enable at 1, the reboot request is high for exactly one cycle, on the same edge the status falls. With the enable at 0, it stays low.
- R8: With the echo select at 1, the fourth digital output shows the watchdog status. With the echo select at 0, it shows the software output bit 3.
- R9: The register readback is {8'h00, enable, 3'b000, leds}. Bits 15..8 and 6..4 always read 0, whatever was written to them.
- R10: A read that coincides with the expiring edge takes priority: no timeout occurs and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| board_rd_i | input | 1 | Strobe, one cycle per read access to any board register |
| reg_wr_i | input | 1 | Write strobe for the latch register |
| wr_data_i | input | 16 | Write data for the latch register |
| echo_sel_i | input | 1 | 1: digital output 3 echoes the watchdog status; 0: it shows the software bit |
| sw_out3_i | input | 1 | Software-driven value for digital output 3 |
| wd_ok_o | output | 1 | Watchdog OK status (bit 0 of the status word) |
| lamp_green_o | output | 1 | Green half of the two-colour indicator |
| lamp_red_o | output | 1 | Red half of the two-colour indicator |
| boot_led_o | output | 4 | Four latched status LEDs |
| auto_rst_en_o | output | 1 | Automatic-reset enable |
| reboot_req_o | output | 1 | One-cycle reboot request on timeout |
| dout3_o | output | 1 | Fourth digital output |
| regval_o | output | 16 | Latch register readback |

## Verification
The bench places reads one edge before expiry, exactly at the expiring edge, and one edge late. These cases catch an off-by-one limit or a read that loses to the expiry, either of which would move or falsely produce the falling edge of the status. It places a write inside an idle window to expose a design that lets writes restart the timer. It checks the reboot pulse on the cycle after timeout to catch a request held as a level. It writes all-ones data to show that the reserved bits never read back as 1.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned LED_W    = 4;
  localparam int unsigned AUTO_BIT = 7;

  typedef struct packed {
    logic             auto_en;
    logic [LED_W-1:0] led;
  } latch_t;

  // Place the latch fields at their register positions; the rest are zero.
  function automatic logic [REG_W-1:0] pack_reg(input latch_t l);
    logic [REG_W-1:0] r;
    r = '0;
    r[LED_W-1:0] = l.led;
    r[AUTO_BIT]  = l.auto_en;
    return r;
  endfunction

  function automatic latch_t unpack_reg(input logic [REG_W-1:0] d);
    latch_t l;
    l.led     = d[LED_W-1:0];
    l.auto_en = d[AUTO_BIT];
    return l;
  endfunction

  // Next value of the idle counter.
  function automatic logic [31:0] next_idle(input logic [31:0] cnt,
                                            input logic restart);
    return restart ? 32'd0 : cnt + 32'd1;
  endfunction
endpackage

// File: rtl/pw_timer.sv
module pw_timer #(
  parameter int unsigned TIMEOUT_CYC = 200_000_000,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ok_o,
  output logic expire_o
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;
  logic          at_limit_w;
  logic [31:0]   nxt_w;

  assign at_limit_w = (cnt_q == LIMIT);
  assign expire_o   = ok_q && !restart_i && at_limit_w;
  assign nxt_w      = pw_pkg::next_idle(32'(cnt_q), restart_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
    end else if (expire_o) begin
      ok_q  <= 1'b0;
    end else if (ok_q) begin
      cnt_q <= nxt_w[CW-1:0];
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/pw_latch.sv
module pw_latch
  import pw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  output latch_t           state_o,
  output logic [REG_W-1:0] readback_o
);
  latch_t st_q;
  logic   unused_bits;

  assign unused_bits = ^{data_i[REG_W-1:AUTO_BIT+1], data_i[AUTO_BIT-1:LED_W]};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) st_q <= '0;
    else if (wr_i) st_q <= unpack_reg(data_i);
  end

  assign state_o    = st_q;
  assign readback_o = pack_reg(st_q);
endmodule

// File: rtl/pw_indicate.sv
module pw_indicate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic expire_i,
  input  logic auto_en_i,
  input  logic echo_sel_i,
  input  logic sw_out3_i,
  output logic green_o,
  output logic red_o,
  output logic reboot_o,
  output logic dout3_o
);
  logic reboot_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) reboot_q <= 1'b0;
    else         reboot_q <= expire_i && auto_en_i;
  end

  assign green_o  = ok_i;
  assign red_o    = !ok_i;
  assign reboot_o = reboot_q;
  assign dout3_o  = echo_sel_i ? ok_i : sw_out3_i;
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        board_rd_i,
  input  logic        reg_wr_i,
  input  logic [15:0] wr_data_i,
  input  logic        echo_sel_i,
  input  logic        sw_out3_i,
  output logic        wd_ok_o,
  output logic        lamp_green_o,
  output logic        lamp_red_o,
  output logic [3:0]  boot_led_o,
  output logic        auto_rst_en_o,
  output logic        reboot_req_o,
  output logic        dout3_o,
  output logic [15:0] regval_o
);
  import pw_pkg::*;

  logic   ok_w;
  logic   expire_w;
  latch_t latch_w;

  pw_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(board_rd_i),
    .ok_o     (ok_w),
    .expire_o (expire_w)
  );

  pw_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .data_i    (wr_data_i),
    .state_o   (latch_w),
    .readback_o(regval_o)
  );

  pw_indicate u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ok_i      (ok_w),
    .expire_i  (expire_w),
    .auto_en_i (latch_w.auto_en),
    .echo_sel_i(echo_sel_i),
    .sw_out3_i (sw_out3_i),
    .green_o   (lamp_green_o),
    .red_o     (lamp_red_o),
    .reboot_o  (reboot_req_o),
    .dout3_o   (dout3_o)
  );

  assign wd_ok_o       = ok_w;
  assign boot_led_o    = latch_w.led;
  assign auto_rst_en_o = latch_w.auto_en;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int unsigned TIMEOUT_CYC = 200_000_000,
  localparam int unsigned IW = $clog2(TIMEOUT_CYC + 2)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        board_rd_i,
  input logic        wd_ok_o,
  input logic        lamp_green_o,
  input logic        lamp_red_o,
  input logic        reboot_req_o,
  input logic        auto_rst_en_o,
  input logic [15:0] regval_o
);
  localparam logic [IW-1:0] TCNT = IW'(TIMEOUT_CYC);

  logic [IW-1:0] idle_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                  idle_q <= '0;
    else if (board_rd_i)          idle_q <= '0;
    else if (idle_q <= TCNT)      idle_q <= idle_q + 1'b1;
  end

  p_timeout_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_ok_o) |-> (idle_q == TCNT));
  p_hold_failed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_ok_o && !board_rd_i) |=> !wd_ok_o);
  p_read_restores_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rd_i |=> wd_ok_o);
  p_lamp_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({lamp_green_o, lamp_red_o}) && (lamp_green_o == wd_ok_o));
  p_reboot_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_req_o |=> !reboot_req_o);
  p_reboot_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_req_o |-> ($fell(wd_ok_o) && $past(auto_rst_en_o)));
  p_zero_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regval_o[15:8] == 8'h00) && (regval_o[6:4] == 3'b000));
endmodule

bind poll_watchdog pw_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .board_rd_i   (board_rd_i),
  .wd_ok_o      (wd_ok_o),
  .lamp_green_o (lamp_green_o),
  .lamp_red_o   (lamp_red_o),
  .reboot_req_o (reboot_req_o),
  .auto_rst_en_o(auto_rst_en_o),
  .regval_o     (regval_o)
);

// File: tb/poll_watchdog_test.sv
`timescale 1ns/1ps
module poll_watchdog_test;
  localparam int T = 12;

  logic clk = 0, rst_n = 0;
  logic rd = 0, wr = 0, sel = 0, sw = 0;
  logic [15:0] wd = '0;
  logic ok, green, red, auto_en, reboot, dout3;
  logic [3:0] leds;
  logic [15:0] regval;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  poll_watchdog #(.TIMEOUT_CYC(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .board_rd_i(rd), .reg_wr_i(wr),
    .wr_data_i(wd), .echo_sel_i(sel), .sw_out3_i(sw),
    .wd_ok_o(ok), .lamp_green_o(green), .lamp_red_o(red),
    .boot_led_o(leds), .auto_rst_en_o(auto_en), .reboot_req_o(reboot),
    .dout3_o(dout3), .regval_o(regval));

  // {write data, expected readback}
  localparam logic [31:0] VEC [6] = '{
    {16'h0000, 16'h0000}, {16'h00FF, 16'h008F}, {16'hFFFF, 16'h008F},
    {16'h0085, 16'h0085}, {16'hA37A, 16'h000A}, {16'h000C, 16'h000C}};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1; @(negedge clk); rd = 0;
  endtask

  task automatic do_write(logic [15:0] d);
    wr = 1; wd = d; @(negedge clk); wr = 0; wd = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    check("R1 ok", 16'(ok), 16'h1);
    check("R1 leds/en", regval, 16'h0000);
    check("R1 reboot", 16'(reboot), 16'h0);
    // R3 from reset release
    idle(T - 1);
    check("R3 ok before limit", 16'(ok), 16'h1);
    idle(1);
    check("R3 ok falls at limit", 16'(ok), 16'h0);
    check("R5 lamps failed", {14'h0, green, red}, 16'h1);
    check("R7 no reboot when disabled", 16'(reboot), 16'h0);
    // R4 stays failed
    idle(5);
    check("R4 held failed", 16'(ok), 16'h0);
    do_read();
    check("R4 read restores", 16'(ok), 16'h1);
    check("R5 lamps ok", {14'h0, green, red}, 16'h2);

    // R6/R9 table walk
    foreach (VEC[i]) begin
      do_read();
      do_write(VEC[i][31:16]);
      check("R9 readback", regval, VEC[i][15:0]);
      check("R6 leds", 16'(leds), 16'(VEC[i][19:16]));
      check("R6 enable", 16'(auto_en), 16'(VEC[i][23]));
    end

    // R2 reads spaced T-1 apart keep OK
    for (int k = 0; k < 4; k++) begin
      do_read();
      idle(T - 2);
      check("R2 ok with polling", 16'(ok), 16'h1);
    end

    // R6 write does not restart the count
    do_read();
    idle(T - 3);
    do_write(16'h0003);
    idle(1);
    check("R6 ok before limit after write", 16'(ok), 16'h1);
    idle(1);
    check("R6 write did not restart", 16'(ok), 16'h0);

    // R10 read on the expiring edge wins
    do_read();
    idle(T - 1);
    do_read();
    check("R10 coincident read keeps ok", 16'(ok), 16'h1);
    idle(T - 1);
    check("R10 full period after", 16'(ok), 16'h1);
    idle(1);
    check("R10 then expires", 16'(ok), 16'h0);

    // R7 reboot pulse when enabled (bit 7)
    do_write(16'h0080);
    do_read();
    idle(T - 1);
    check("R7 no early reboot", 16'(reboot), 16'h0);
    idle(1);
    check("R7 reboot pulse", {14'h0, reboot, ok}, 16'h2);
    idle(1);
    check("R7 pulse one cycle", 16'(reboot), 16'h0);
    idle(T + 3);
    check("R7 no repeat", 16'(reboot), 16'h0);

    // R8 echo select (currently failed, ok=0)
    sel = 0; sw = 1; idle(1);
    check("R8 sw bit shown", 16'(dout3), 16'h1);
    sel = 1; idle(1);
    check("R8 status echoed failed", 16'(dout3), 16'h0);
    do_read();
    check("R8 status echoed ok", 16'(dout3), 16'h1);
    sel = 0; sw = 0; idle(1);
    check("R8 sw bit low", 16'(dout3), 16'h0);

    // R1 reset mid-run
    do_write(16'h008F);
    rst_n = 0; idle(2); rst_n = 1;
    check("R1 reset clears latch", regval, 16'h0000);
    check("R1 reset ok", 16'(ok), 16'h1);

    done = 1;
    finish_run();
  end
endmodule